// File: doc/BRIEF.md
# Chunk Hamming Check-Code Generator for NAND Pages

This block builds a 22-bit single-error-correcting check code over a 256-byte slice of NAND flash data while the bytes stream past, one byte per cycle in which the valid strobe is high. It keeps two sets of running parities. Line parities are folded by the byte's position in the chunk. Column parities are folded by the bit's position inside each byte. Software stores the code beside the data. On read-back it XORs the stored code with a freshly generated one, and a single flipped bit then shows up directly as its byte address and bit index. Locating and repairing that bit is left to software.

A start pulse opens each chunk. It clears the accumulators and the byte count, and it throws away any chunk that is only partly gathered. Once the 256th byte has been taken, a done flag rises. The code then stays frozen until the next start, and any further bytes are dropped. A page made of several chunks is handled by pulsing start again before each chunk.

Top module: `hamm_chunk_ecc`

## Requirements
- R1: After reset, `done_o` is 0 and `ecc_o` is all zeros.
- R2: Line field. For each byte-address bit k (0..7), `ecc_o[2k+1]` is the XOR of every data bit in the bytes whose address has bit k set. `ecc_o[2k]` is the same XOR over the bytes whose address has bit k clear. Byte address is the 0-based order of acceptance within the chunk.
- R3: Column field. For each bit-index bit j (0..2), `ecc_o[16+2j+1]` is the XOR over all bytes of the data bits whose index has bit j set. `ecc_o[16+2j]` is the same XOR over the bits whose index has bit j clear. Bit index 0 is `byte_i[0]`.
- R4: `done_o` is 0 while fewer than 256 bytes have been accepted. It reads 1 in the cycle after the edge that accepts the 256th byte.
- R5: While `done_o` is 1 and no start arrives, `done_o` and `ecc_o` hold their values, and bytes offered with `valid_i` high have no effect.
- R6: A start pulse clears the count, both parity fields and `done_o` at the next edge, and it aborts any partial chunk. A byte offered in the same cycle as start is discarded.
- R7: Cycles with `valid_i` low neither advance the byte count nor change the parities, whatever `byte_i` holds.
- R8: If exactly one data bit of a chunk is flipped, the XOR of the two codes has, for every pair, exactly one bit set. The odd member of pair k is set exactly when address bit k of the flipped byte is 1. The odd member of column pair j is set exactly when bit j of the flipped bit's index is 1.
- R9: When `done_o` is 1, every pair (both line and column) XORs to the same value, namely the parity of all 2048 data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears state and opens a new chunk |
| valid_i | input | 1 | Qualifies `byte_i` in this cycle |
| byte_i | input | 8 | Data byte |
| ecc_o | output | 22 | Column field [21:16], line field [15:0] |
| done_o | output | 1 | Chunk complete; code valid and frozen |

## Verification
A wrong byte count shows up at the port as `done_o` rising one or more cycles early or late. It also shows up in the line field, because the address used to pick between the odd and even member of each pair is the count itself. A single-bit slip therefore breaks the address-encoding check on the flipped-bit sweep as soon as that chunk ends. An accumulator that is not cleared, or that keeps absorbing bytes after completion, appears in `ecc_o` one cycle after the start or the extra byte. The pair-parity rule catches any member that was toggled alone, at the moment `done_o` rises.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
    parameter int CHUNK_ADDR_W = 8;                       // 2**8 = 256 bytes per chunk
    parameter int BYTE_W       = 8;
    localparam int BIT_IDX_W   = $clog2(BYTE_W);
    localparam int LINE_W      = 2 * CHUNK_ADDR_W;
    localparam int COL_W       = 2 * BIT_IDX_W;
    localparam int ECC_W       = LINE_W + COL_W;
endpackage

// File: rtl/hecc_col_fold.sv
// Column pair bits for one byte: pair j splits the bits by bit j of their index.
module hecc_col_fold #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  data_i,
    output logic [2*IDX_W-1:0] col_o
);
    for (genvar j = 0; j < IDX_W; j++) begin : g_pair
        always_comb begin
            logic hi;
            logic lo;
            hi = 1'b0;
            lo = 1'b0;
            for (int i = 0; i < DATA_W; i++) begin
                if (((i >> j) & 1) == 1) hi ^= data_i[i];
                else                     lo ^= data_i[i];
            end
            col_o[2*j+1] = hi;
            col_o[2*j]   = lo;
        end
    end
endmodule

// File: rtl/hecc_line_mask.sv
// Line toggle mask: the parity of a byte lands on the odd or even member of each
// pair, chosen by the matching bit of that byte's address.
module hecc_line_mask #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                par_i,
    output logic [2*ADDR_W-1:0] mask_o
);
    for (genvar k = 0; k < ADDR_W; k++) begin : g_pair
        assign mask_o[2*k+1] = par_i &  addr_i[k];
        assign mask_o[2*k]   = par_i & ~addr_i[k];
    end
endmodule

// File: rtl/hamm_chunk_ecc.sv
module hamm_chunk_ecc #(
    parameter int ADDR_W = hecc_pkg::CHUNK_ADDR_W,
    parameter int DATA_W = hecc_pkg::BYTE_W,
    localparam int IDX_W  = $clog2(DATA_W),
    localparam int LINE_W = 2 * ADDR_W,
    localparam int COL_W  = 2 * IDX_W,
    localparam int ECC_W  = LINE_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic [ECC_W-1:0]  ecc_o,
    output logic              done_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] cnt;
        logic              full;
        logic [LINE_W-1:0] line;
        logic [COL_W-1:0]  col;
    } acc_t;

    acc_t st_d, st_q;
    logic [LINE_W-1:0] line_mask;
    logic [COL_W-1:0]  col_bits;
    logic              accept;

    hecc_line_mask #(.ADDR_W(ADDR_W)) u_line (
        .addr_i (st_q.cnt),
        .par_i  (^byte_i),
        .mask_o (line_mask)
    );

    hecc_col_fold #(.DATA_W(DATA_W)) u_col (
        .data_i (byte_i),
        .col_o  (col_bits)
    );

    always_comb begin
        st_d   = st_q;
        accept = valid_i && !st_q.full;
        if (start_i) begin
            st_d = '0;
        end else if (accept) begin
            st_d.line = st_q.line ^ line_mask;
            st_d.col  = st_q.col ^ col_bits;
            st_d.cnt  = st_q.cnt + 1'b1;
            if (&st_q.cnt) st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ecc_o  = {st_q.col, st_q.line};
    assign done_o = st_q.full;
endmodule

// File: rtl/hamm_chunk_ecc_chk.sv
module hamm_chunk_ecc_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W  = $clog2(DATA_W),
    localparam int NPAIR  = ADDR_W + IDX_W,
    localparam int ECC_W  = 2 * NPAIR
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             valid_i,
    input logic [ECC_W-1:0] ecc_o,
    input logic             done_o
);
    logic [NPAIR-1:0] pair_x;
    always_comb begin
        for (int p = 0; p < NPAIR; p++) pair_x[p] = ecc_o[2*p] ^ ecc_o[2*p+1];
    end

    p_reset_clear_r1: assert property (@(posedge clk) $rose(rst_n) |-> !done_o && ecc_o == '0);

    p_done_needs_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(valid_i && !start_i));

    p_hold_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o && $stable(ecc_o));

    p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !done_o && ecc_o == '0);

    p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i && !start_i |=> $stable(ecc_o) && $stable(done_o));

    p_pairs_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pair_x == '0) || (&pair_x));
endmodule

bind hamm_chunk_ecc hamm_chunk_ecc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .valid_i (valid_i),
    .ecc_o   (ecc_o),
    .done_o  (done_o)
);

// File: tb/hamm_chunk_ecc_test.sv
`timescale 1ns/1ps
module hamm_chunk_ecc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        valid_i = 1'b0;
    logic [7:0]  byte_i = 8'h00;
    logic [21:0] ecc_o;
    logic        done_o;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] mem [256];

    always #4 clk = ~clk;

    hamm_chunk_ecc uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
        .byte_i(byte_i), .ecc_o(ecc_o), .done_o(done_o)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [21:0] model();
        logic [21:0] r = '0;
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 8; b++)
                if (mem[a][b]) begin
                    for (int k = 0; k < 8; k++) r[2*k + ((a >> k) & 1)] ^= 1'b1;
                    for (int j = 0; j < 3; j++) r[16 + 2*j + ((b >> j) & 1)] ^= 1'b1;
                end
        return r;
    endfunction

    task automatic pulse_start(input logic with_byte);
        @(negedge clk);
        start_i = 1'b1; valid_i = with_byte; byte_i = 8'hFF;
        @(negedge clk);
        start_i = 1'b0; valid_i = 1'b0;
        chk(done_o == 1'b0 && ecc_o == '0, "R6 start clears", {9'd0, done_o, ecc_o}, 32'd0);
    endtask

    task automatic feed(input logic gaps, input string tag);
        for (int i = 0; i < 256; i++) begin
            if (gaps && (i % 5 == 2)) begin
                @(negedge clk); valid_i = 1'b0; byte_i = 8'hA5;
            end
            @(negedge clk); valid_i = 1'b1; byte_i = mem[i];
            if (i == 255) chk(done_o == 1'b0, {"R4 early done ", tag}, done_o, 0);
        end
        @(negedge clk); valid_i = 1'b0;
        chk(done_o == 1'b1, {"R4 done ", tag}, done_o, 1);
        chk(ecc_o == model(), {"R2/R3 code ", tag}, ecc_o, model());
    endtask

    task automatic pair_check(input string tag);
        logic par = 1'b0;
        logic ok = 1'b1;
        for (int a = 0; a < 256; a++) par ^= ^mem[a];
        for (int p = 0; p < 11; p++) if ((ecc_o[2*p] ^ ecc_o[2*p+1]) != par) ok = 1'b0;
        chk(ok, {"R9 pair parity ", tag}, ecc_o, {31'd0, par});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [21:0] base;
        logic [21:0] diff;
        logic [21:0] want;
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        chk(done_o == 1'b0 && ecc_o == '0, "R1 reset", {9'd0, done_o, ecc_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_o == 1'b0 && ecc_o == '0, "R1 after release", {9'd0, done_o, ecc_o}, 0);

        // pattern sweep
        for (int pat = 0; pat < 6; pat++) begin
            lfsr = 32'h1234_5678 + pat;
            for (int a = 0; a < 256; a++) begin
                case (pat)
                    0: mem[a] = 8'h00;
                    1: mem[a] = 8'hFF;
                    2: mem[a] = a[7:0];
                    3: mem[a] = (a == 77) ? 8'h10 : 8'h00;
                    default: begin
                        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
                        mem[a] = lfsr[23:16];
                    end
                endcase
            end
            pulse_start(1'b0);
            feed(pat[0], "R7 pattern");
            pair_check("pattern");
        end

        // R5: extra bytes after completion are ignored
        base = ecc_o;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); valid_i = 1'b1; byte_i = 8'h5A + i[7:0];
            @(negedge clk); valid_i = 1'b0;
            chk(done_o == 1'b1 && ecc_o == base, "R5 hold", ecc_o, base);
        end

        // R6: abort mid-chunk, and a byte offered with start is dropped
        pulse_start(1'b0);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); valid_i = 1'b1; byte_i = 8'hC3 ^ i[7:0];
        end
        @(negedge clk); valid_i = 1'b0;
        chk(done_o == 1'b0, "R6 partial not done", done_o, 0);
        pulse_start(1'b1);
        feed(1'b0, "R6 after abort");

        // R8: single-bit flips against a fixed base chunk
        pulse_start(1'b0);
        feed(1'b0, "R8 base");
        base = ecc_o;
        for (int f = 0; f < 64; f++) begin
            int a;
            int b;
            a = (f * 37 + 11) % 256;
            b = f % 8;
            mem[a][b] = ~mem[a][b];
            pulse_start(1'b0);
            feed(f[0], "R8 flipped");
            diff = ecc_o ^ base;
            for (int k = 0; k < 8; k++) begin
                want[2*k+1] = ((a >> k) & 1) == 1;
                want[2*k]   = ((a >> k) & 1) == 0;
            end
            for (int j = 0; j < 3; j++) begin
                want[16+2*j+1] = ((b >> j) & 1) == 1;
                want[16+2*j]   = ((b >> j) & 1) == 0;
            end
            chk(diff == want, "R8 flip locates bit", diff, want);
            mem[a][b] = ~mem[a][b];
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule